// File: doc/BRIEF.md
# Serial Receive Buffer with Flow Control

This block is the receive half of one asynchronous serial channel. It samples the line at sixteen times the bit rate and checks the start bit in the middle of the bit. It then collects 5 to 8 data bits, least significant first, plus an optional parity bit and one stop bit. Each finished character goes into a first-in first-out store together with its own parity and framing flags. The store holds a parameter number of characters, 8 or 16.

A processor reads characters through a show-ahead read port. It sees a ready flag and a full flag. The interrupt line follows one of these two flags, chosen by a mode input. Error flags show either the character at the head of the store or a sticky record of every error stored since the last clear command. A request-to-send output can be dropped automatically while the store is full. In multi-drop mode the parity slot carries an address/data tag. Until an address character arrives, characters tagged as data are thrown away.

The receive state machine has six states. IDLE goes to START on a tick that sees the line low. START goes to DATA if the line is still low at its eighth sample, and back to IDLE if it is high. DATA goes to PARITY after the last data bit when a parity slot is configured, and to STOP when none is. PARITY always goes to STOP. STOP goes to IDLE when the stop sample is high, and to HOLD when it is low. HOLD returns to IDLE on the first tick that sees the line high.

Top module: `uart_rx_buffer`

## Requirements
- R1: On a `baud_tick` that sees the line low, a character starts; the start bit is confirmed at the 8th tick and a high line there abandons the frame, storing nothing. Data bits are taken every 16 ticks after that, LSB first. The count is set by `cfg_len` (00=5, 01=6, 10=7, 11=8 bits), and `rd_data` returns the bits right-aligned with the unused upper bits zero.
- R2: `cfg_par_mode` 00 checks parity (even when `cfg_par_odd`=0, odd when 1). Mode 01 expects the parity bit to equal `cfg_par_odd`. Mode 10 has no parity bit. A mismatch marks that character's parity error.
- R3: A stop bit sampled low marks that character's framing error. The receiver then waits for the line to go high before it looks for a new start bit.
- R4: `st_ready` is 1 exactly while the store holds a character. A pulse on `rd_en` removes the head character. `rd_en` while the store is empty has no effect.
- R5: `st_full` is 1 exactly while the store holds DEPTH characters.
- R6: A character completed while the store is full is dropped and sets `st_overrun`. Only `cmd_err_reset` clears it.
- R7: `irq` follows `st_ready` when `cfg_irq_full`=0 and follows `st_full` when it is 1.
- R8: With `cfg_err_block`=0, `st_parity_err` and `st_frame_err` show the head character's flags (0 when empty). With 1, they hold the OR of the flags of every character stored since the last `cmd_err_reset`.
- R9: `cmd_rts_set` and `cmd_rts_clr` set and clear a request bit. `rts_out` is that bit, forced to 0 while `cfg_auto_rts`=1 and the store is full. The bit is 0 after reset.
- R10: `cfg_par_mode`=11 selects multi-drop: the parity slot is a tag (1=address). While not addressed, tag-0 characters are discarded. A tag-1 character is accepted and makes the receiver addressed, after which all characters are accepted. `cmd_unaddress` clears that state, and `rd_tag` shows the head tag.
- R11: Characters leave the store in arrival order, including when the pointers wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Enable at 16x the bit rate |
| rxd | input | 1 | Serial line input |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par_mode | input | 2 | 00 parity, 01 forced, 10 none, 11 multi-drop |
| cfg_par_odd | input | 1 | Odd parity / forced bit value |
| cfg_err_block | input | 1 | Accumulated error reporting |
| cfg_irq_full | input | 1 | Interrupt from full instead of ready |
| cfg_auto_rts | input | 1 | Drop RTS while full |
| cmd_rts_set | input | 1 | Set request-to-send bit |
| cmd_rts_clr | input | 1 | Clear request-to-send bit |
| cmd_err_reset | input | 1 | Clear overrun and accumulated errors |
| cmd_unaddress | input | 1 | Leave the addressed state |
| rd_en | input | 1 | Pop the head character |
| rd_data | output | 8 | Head character data |
| rd_tag | output | 1 | Head character address tag |
| st_ready | output | 1 | Store not empty |
| st_full | output | 1 | Store full |
| st_overrun | output | 1 | Character lost |
| st_parity_err | output | 1 | Parity error flag |
| st_frame_err | output | 1 | Framing error flag |
| irq | output | 1 | Receive interrupt |
| rts_out | output | 1 | Request to send, active high |

## Verification
The line goes through a two-flop synchronizer. The stop bit is sampled mid-bit, the finished character is registered one clock later, and the store write happens one clock after that. The ready, full, error and request-to-send outputs therefore change a few clocks after the middle of the stop bit. A read, a command or a configuration change shows on the outputs one clock later, or at once for configuration-only outputs. The bench updates its reference model only once the whole stop bit has been driven, which is half a bit after the design acts. It compares every output on each falling edge, but only inside settled windows that contain no frame. Read and command pulses update the model just after the rising edge that acts on them, so each falling-edge comparison sees both sides in the same state.

// File: rtl/urx_pkg.sv
package urx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       tag;
        logic       perr;
        logic       ferr;
    } rx_char_t;

    localparam logic [1:0] PM_PARITY = 2'b00;
    localparam logic [1:0] PM_FORCE  = 2'b01;
    localparam logic [1:0] PM_NONE   = 2'b10;
    localparam logic [1:0] PM_MULTI  = 2'b11;

endpackage

// File: rtl/urx_sampler.sv
module urx_sampler
    import urx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par_mode,
    input  logic       cfg_par_odd,
    output logic       out_valid,
    output rx_char_t   out_char
);
    localparam int          CW   = $clog2(OVS);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    rx_state_e     state, state_nx;
    logic [1:0]    sync;
    logic          rxs;
    logic [CW-1:0] cnt;
    logic [2:0]    bit_idx;
    logic [2:0]    last_bit;
    logic [7:0]    shreg;
    logic          par_acc, par_bit, perr_c;
    logic          sample_pt, has_par;

    assign rxs       = sync[1];
    assign last_bit  = 3'd4 + {1'b0, cfg_len};
    assign has_par   = (cfg_par_mode != PM_NONE);
    assign sample_pt = tick && (cnt == ((state == RX_START) ? MID : LAST));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:   if (tick && !rxs) state_nx = RX_START;
            RX_START:  if (sample_pt) state_nx = rxs ? RX_IDLE : RX_DATA;
            RX_DATA:   if (sample_pt && bit_idx == last_bit)
                           state_nx = has_par ? RX_PARITY : RX_STOP;
            RX_PARITY: if (sample_pt) state_nx = RX_STOP;
            RX_STOP:   if (sample_pt) state_nx = rxs ? RX_IDLE : RX_HOLD;
            RX_HOLD:   if (tick && rxs) state_nx = RX_IDLE;
            default:   state_nx = RX_IDLE;
        endcase
    end

    always_comb begin
        case (cfg_par_mode)
            PM_PARITY: perr_c = par_acc ^ par_bit ^ cfg_par_odd;
            PM_FORCE:  perr_c = par_bit ^ cfg_par_odd;
            default:   perr_c = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            par_acc   <= 1'b0;
            par_bit   <= 1'b0;
            out_valid <= 1'b0;
            out_char  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (tick) begin
                unique case (state)
                    RX_IDLE: begin
                        cnt     <= CW'(1);
                        bit_idx <= '0;
                        shreg   <= '0;
                        par_acc <= 1'b0;
                        par_bit <= 1'b0;
                    end
                    RX_HOLD: cnt <= '0;
                    default: cnt <= sample_pt ? '0 : cnt + 1'b1;
                endcase
                if (sample_pt) begin
                    case (state)
                        RX_DATA: begin
                            shreg   <= {rxs, shreg[7:1]};
                            par_acc <= par_acc ^ rxs;
                            bit_idx <= bit_idx + 3'd1;
                        end
                        RX_PARITY: par_bit <= rxs;
                        RX_STOP: begin
                            out_valid     <= 1'b1;
                            out_char.data <= shreg >> (3'd7 - last_bit);
                            out_char.tag  <= (cfg_par_mode == PM_MULTI) ? par_bit : 1'b0;
                            out_char.perr <= perr_c;
                            out_char.ferr <= ~rxs;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R1: a character takes many ticks, so completions never come back to back
    assert_valid_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R3: after a low stop sample the machine must wait in HOLD
    assert_hold_after_break_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_char.ferr && !rxs) |-> (state == RX_HOLD));

endmodule

// File: rtl/urx_fifo.sv
module urx_fifo
    import urx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  rx_char_t      din,
    input  logic          pop,
    output rx_char_t      head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    rx_char_t      mem [DEPTH];
    logic [AW-1:0] wp, rp;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= step(wp);
            if (pop)  rp <= step(rp);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    assert_count_grows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import urx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OVS   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par_mode,
    input  logic       cfg_par_odd,
    input  logic       cfg_err_block,
    input  logic       cfg_irq_full,
    input  logic       cfg_auto_rts,
    input  logic       cmd_rts_set,
    input  logic       cmd_rts_clr,
    input  logic       cmd_err_reset,
    input  logic       cmd_unaddress,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_tag,
    output logic       st_ready,
    output logic       st_full,
    output logic       st_overrun,
    output logic       st_parity_err,
    output logic       st_frame_err,
    output logic       irq,
    output logic       rts_out
);
    localparam int CW = $clog2(DEPTH) + 1;

    rx_char_t      ch, head;
    logic          ch_valid, md, accept, push, pop;
    logic          full, empty;
    logic [CW-1:0] fifo_count;
    logic          overrun, blk_pe, blk_fe, addressed, rts_req;

    urx_sampler #(.OVS(OVS)) u_sampler (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (baud_tick),
        .rxd          (rxd),
        .cfg_len      (cfg_len),
        .cfg_par_mode (cfg_par_mode),
        .cfg_par_odd  (cfg_par_odd),
        .out_valid    (ch_valid),
        .out_char     (ch)
    );

    urx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (ch),
        .pop   (pop),
        .head  (head),
        .count (fifo_count),
        .full  (full),
        .empty (empty)
    );

    assign md     = (cfg_par_mode == PM_MULTI);
    assign accept = ch_valid && (!md || addressed || ch.tag);
    assign push   = accept && !full;
    assign pop    = rd_en && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun   <= 1'b0;
            blk_pe    <= 1'b0;
            blk_fe    <= 1'b0;
            addressed <= 1'b0;
            rts_req   <= 1'b0;
        end else begin
            overrun <= (overrun && !cmd_err_reset) || (accept && full);
            blk_pe  <= (blk_pe  && !cmd_err_reset) || (push && ch.perr);
            blk_fe  <= (blk_fe  && !cmd_err_reset) || (push && ch.ferr);
            if (cmd_unaddress)                addressed <= 1'b0;
            else if (ch_valid && md && ch.tag) addressed <= 1'b1;
            if (cmd_rts_set)      rts_req <= 1'b1;
            else if (cmd_rts_clr) rts_req <= 1'b0;
        end
    end

    always_comb begin
        st_ready      = !empty;
        st_full       = full;
        st_overrun    = overrun;
        rd_data       = empty ? 8'h00 : head.data;
        rd_tag        = !empty && head.tag;
        st_parity_err = cfg_err_block ? blk_pe : (!empty && head.perr);
        st_frame_err  = cfg_err_block ? blk_fe : (!empty && head.ferr);
        irq           = cfg_irq_full ? full : !empty;
        rts_out       = rts_req && !(cfg_auto_rts && full);
    end

    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_overrun && !cmd_err_reset) |=> st_overrun);

    assert_md_discard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && md && !addressed && !ch.tag && !rd_en && !cmd_err_reset)
            |=> ($stable(fifo_count) && $stable(st_overrun)));

    assert_ready_after_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> st_ready);

endmodule

// File: tb/uart_rx_buffer_bench.sv
module uart_rx_buffer_bench;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0, baud_tick = 1'b0, rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3, cfg_par_mode = 2'b10;
    logic       cfg_par_odd = 0, cfg_err_block = 0, cfg_irq_full = 0, cfg_auto_rts = 0;
    logic       cmd_rts_set = 0, cmd_rts_clr = 0, cmd_err_reset = 0, cmd_unaddress = 0, rd_en = 0;
    logic [7:0] rd_data;
    logic       rd_tag, st_ready, st_full, st_overrun, st_parity_err, st_frame_err, irq, rts_out;

    int tcnt = 0;
    always @(negedge clk) begin
        baud_tick <= (tcnt == 3);
        tcnt      <= (tcnt + 1) % 4;
    end

    uart_rx_buffer #(.DEPTH(DEPTH)) u_uart_rx_buffer (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_mode(cfg_par_mode), .cfg_par_odd(cfg_par_odd),
        .cfg_err_block(cfg_err_block), .cfg_irq_full(cfg_irq_full), .cfg_auto_rts(cfg_auto_rts),
        .cmd_rts_set(cmd_rts_set), .cmd_rts_clr(cmd_rts_clr), .cmd_err_reset(cmd_err_reset),
        .cmd_unaddress(cmd_unaddress), .rd_en(rd_en), .rd_data(rd_data), .rd_tag(rd_tag),
        .st_ready(st_ready), .st_full(st_full), .st_overrun(st_overrun),
        .st_parity_err(st_parity_err), .st_frame_err(st_frame_err), .irq(irq), .rts_out(rts_out)
    );

    typedef struct packed {
        logic [7:0] d;
        logic       tag;
        logic       pe;
        logic       fe;
    } ent_t;

    ent_t q[$];
    bit   m_ovr = 0, m_bpe = 0, m_bfe = 0, m_addr = 0, m_rts = 0;
    bit   settled = 0;
    int   nchk = 0, nfail = 0;

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string req, input string what);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit         rdy  = (q.size() != 0);
        bit         ful  = (q.size() == DEPTH);
        logic [7:0] d    = rdy ? q[0].d : 8'h00;
        bit         tg   = rdy ? q[0].tag : 1'b0;
        bit         pe   = cfg_err_block ? m_bpe : (rdy ? q[0].pe : 1'b0);
        bit         fe   = cfg_err_block ? m_bfe : (rdy ? q[0].fe : 1'b0);
        bit         ir   = cfg_irq_full ? ful : rdy;
        bit         rt   = m_rts && !(cfg_auto_rts && ful);
        check(32'(st_ready), 32'(rdy), "R4", "ready");
        check(32'(st_full), 32'(ful), "R5", "full");
        check(32'(rd_data), 32'(d), "R1 R11", "data");
        check(32'(rd_tag), 32'(tg), "R10", "tag");
        check(32'(st_overrun), 32'(m_ovr), "R6", "overrun");
        check(32'(st_parity_err), 32'(pe), "R2 R8", "parity_err");
        check(32'(st_frame_err), 32'(fe), "R3 R8", "frame_err");
        check(32'(irq), 32'(ir), "R7", "irq");
        check(32'(rts_out), 32'(rt), "R9", "rts");
    endtask

    always @(negedge clk) begin
        if (rst_n && settled) compare_all();
    end

    task automatic model_char(input logic [7:0] d, input bit tag, input bit pe, input bit fe);
        bit md = (cfg_par_mode == 2'b11);
        if (md && tag) m_addr = 1;
        else if (md && !m_addr) return;
        if (q.size() == DEPTH) m_ovr = 1;
        else begin
            q.push_back('{d: d, tag: md ? tag : 1'b0, pe: pe, fe: fe});
            m_bpe |= pe;
            m_bfe |= fe;
        end
    endtask

    task automatic bit_time();
        repeat (64) @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [7:0] d, input bit tag, input bit corrupt, input bit stop_bit);
        int         nb = 5 + int'(cfg_len);
        logic [7:0] dm = d & 8'((1 << nb) - 1);
        bit         pb;
        @(posedge clk); #1;
        settled = 0;
        case (cfg_par_mode)
            2'b00:   pb = (^dm) ^ cfg_par_odd ^ corrupt;
            2'b01:   pb = cfg_par_odd ^ corrupt;
            default: pb = tag;
        endcase
        rxd = 1'b0; bit_time();
        for (int i = 0; i < nb; i++) begin rxd = dm[i]; bit_time(); end
        if (cfg_par_mode != 2'b10) begin rxd = pb; bit_time(); end
        rxd = stop_bit; bit_time();
        rxd = 1'b1;
        if (!stop_bit) bit_time();
        model_char(dm, tag, corrupt && (cfg_par_mode[1] == 1'b0), !stop_bit);
        settled = 1;
        repeat (16) @(posedge clk);
        #1;
    endtask

    task automatic cpu_read();
        @(posedge clk); #1;
        rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
        if (q.size() != 0) void'(q.pop_front());
    endtask

    // which: 0 rts set, 1 rts clear, 2 error reset, 3 unaddress
    task automatic pulse_cmd(input int which);
        @(posedge clk); #1;
        case (which)
            0: cmd_rts_set = 1'b1;
            1: cmd_rts_clr = 1'b1;
            2: cmd_err_reset = 1'b1;
            default: cmd_unaddress = 1'b1;
        endcase
        @(posedge clk); #1;
        {cmd_rts_set, cmd_rts_clr, cmd_err_reset, cmd_unaddress} = 4'b0;
        case (which)
            0: m_rts = 1;
            1: m_rts = 0;
            2: begin m_ovr = 0; m_bpe = 0; m_bfe = 0; end
            default: m_addr = 0;
        endcase
    endtask

    task automatic set_cfg(input logic [1:0] len, input logic [1:0] pm, input logic odd);
        @(posedge clk); #1;
        cfg_len = len; cfg_par_mode = pm; cfg_par_odd = odd;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R4 watchdog: actual=timeout expected=finished");
        finish_run();
    end

    initial begin
        repeat (6) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(32'(st_ready), 0, "R4", "reset ready");
        check(32'(st_full), 0, "R5", "reset full");
        check(32'(st_overrun), 0, "R6", "reset overrun");
        check(32'(irq), 0, "R7", "reset irq");
        check(32'(rts_out), 0, "R9", "reset rts");
        settled = 1;

        // R9: software raises RTS first
        pulse_cmd(0);

        // R1 R2: 8 bits even parity, then a bad parity character
        set_cfg(2'd3, 2'b00, 1'b0);
        send(8'hA5, 0, 0, 1);
        send(8'h3C, 0, 1, 1);
        cpu_read();
        cpu_read();

        // R1 R2: shorter lengths with odd parity, upper bits must read zero
        set_cfg(2'd0, 2'b00, 1'b1);
        send(8'hFF, 0, 0, 1);
        set_cfg(2'd1, 2'b00, 1'b1);
        send(8'h2A, 0, 1, 1);
        set_cfg(2'd2, 2'b01, 1'b1);
        send(8'h55, 0, 0, 1);
        send(8'h66, 0, 1, 1);
        set_cfg(2'd2, 2'b10, 1'b0);
        send(8'h7E, 0, 0, 1);
        repeat (5) cpu_read();

        // R3: low stop bit gives framing error, next character is clean
        set_cfg(2'd3, 2'b10, 1'b0);
        send(8'h81, 0, 0, 0);
        send(8'h42, 0, 0, 1);
        cpu_read();
        cpu_read();

        // R1: glitch shorter than half a bit is not a start bit
        @(posedge clk); #1 rxd = 1'b0;
        repeat (8) @(posedge clk);
        #1 rxd = 1'b1;
        repeat (200) @(posedge clk);
        @(negedge clk);
        check(32'(st_ready), 0, "R1", "false start stored nothing");

        // R4: read on empty has no effect
        cpu_read();
        check(32'(st_ready), 0, "R4", "empty read");

        // R8: block mode keeps errors after the bad character is read
        @(posedge clk); #1 cfg_err_block = 1'b1;
        set_cfg(2'd3, 2'b00, 1'b0);
        send(8'h11, 0, 1, 1);
        send(8'h22, 0, 0, 1);
        cpu_read();
        @(negedge clk);
        check(32'(st_parity_err), 1, "R8", "block error held");
        pulse_cmd(2);
        cpu_read();
        @(posedge clk); #1 cfg_err_block = 1'b0;

        // R5 R6 R7 R9 R11: fill, overrun, auto RTS, drain in order
        @(posedge clk); #1 begin cfg_irq_full = 1'b1; cfg_auto_rts = 1'b1; end
        set_cfg(2'd3, 2'b10, 1'b0);
        for (int i = 0; i < DEPTH; i++) send(8'(8'h30 + i * 7), 0, 0, 1);
        @(negedge clk);
        check(32'(rts_out), 0, "R9", "rts dropped when full");
        send(8'hEE, 0, 0, 1);
        @(negedge clk);
        check(32'(st_overrun), 1, "R6", "overrun set");
        cpu_read();
        @(negedge clk);
        check(32'(rts_out), 1, "R9", "rts back after read");
        check(32'(st_overrun), 1, "R6", "overrun sticky");
        pulse_cmd(2);
        @(posedge clk); #1 cfg_irq_full = 1'b0;
        while (q.size() != 0) cpu_read();
        for (int i = 0; i < 3; i++) send(8'(8'hC0 + i), 0, 0, 1);
        repeat (3) cpu_read();

        // R10: multi-drop filtering
        set_cfg(2'd3, 2'b11, 1'b0);
        pulse_cmd(3);
        send(8'h11, 0, 0, 1);
        @(negedge clk);
        check(32'(st_ready), 0, "R10", "data discarded before address");
        send(8'h80, 1, 0, 1);
        send(8'h22, 0, 0, 1);
        pulse_cmd(3);
        send(8'h33, 0, 0, 1);
        @(negedge clk);
        check(32'(rd_tag), 1, "R10", "head is address");
        cpu_read();
        cpu_read();
        @(negedge clk);
        check(32'(st_ready), 0, "R10", "data after unaddress discarded");

        // R9: software clear
        pulse_cmd(1);
        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule